// File: doc/BRIEF.md
# Phase-Split Shared Memory Arbiter

This block lets an 8-bit processor and a video fetch engine share one single-port RAM without either of them ever waiting. The memory side runs on a clock at twice the processor rate. Each processor cycle is therefore two memory slots. The first slot (phase 1) belongs to the video engine and the second slot (phase 2) belongs to the processor. The processor touches memory in every one of its cycles, including dummy cycles whose data it discards, so every processor cycle gets its own slot.

Ownership is decided by the slot sequence alone. There is no request and no grant. A processor lock input lets the processor keep the video engine off the bus between the read and the write of a read-modify-write. When the lock is high at the end of a processor slot, the next video slot becomes an idle slot and a miss flag is raised for it.

The slot sequencer is a three-state machine:
- `SLOT_VIDEO`: a video fetch.
- `SLOT_HOLD`: an idle slot that replaces a video fetch during a lock.
- `SLOT_CPU`: a processor access.

It has four transitions:
- `T_VID_DONE`: `SLOT_VIDEO` to `SLOT_CPU`.
- `T_HOLD_DONE`: `SLOT_HOLD` to `SLOT_CPU`.
- `T_LOCK`: `SLOT_CPU` to `SLOT_HOLD`, taken when `cpu_lock` is high.
- `T_RELEASE`: `SLOT_CPU` to `SLOT_VIDEO`, taken when `cpu_lock` is low.

The RAM writes on the clock edge and presents read data combinationally for the address it is given.

Top module: `vmx_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first slot after it rises, the block is in a video slot (`phi1`=1, `phi2`=0) with `vid_miss`=0 and `mem_we`=0; `cpu_rdata` and `vid_rdata` are held at 0 during reset.
- R2: `phi1` and `phi2` are always complementary and swap on every clock, so processor slots and phase-1 slots strictly alternate.
- R3: In a non-idle phase-1 slot, `mem_addr` equals `vid_addr`, `mem_en`=1 and `vid_miss`=0.
- R4: In a phase-2 slot, `mem_addr` equals `cpu_addr`, `mem_wdata` equals `cpu_wdata`, `mem_we` equals `cpu_we` and `mem_en`=1.
- R5: `cpu_rdata` loads `mem_rdata` at the clock edge that ends each phase-2 slot (write cycles included), and holds that value through the following phase-1 slot.
- R6: `vid_rdata` loads `mem_rdata` at the edge that ends a non-idle phase-1 slot, and is unchanged at every other edge.
- R7: If `cpu_lock` is 1 at the edge that ends a phase-2 slot, the next phase-1 slot is idle: `mem_en`=0, `mem_we`=0, `vid_miss`=1, and `vid_rdata` keeps its value.
- R8: An idle slot is always followed by a phase-2 slot; the lock never stretches or removes a processor slot.
- R9: `mem_we` is never 1 during a phase-1 slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the processor rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | ADDR_W | Processor address, sampled in phase 2 |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_we | input | 1 | Processor write strobe, 1 = write |
| cpu_lock | input | 1 | Keeps the next phase-1 slot idle |
| cpu_rdata | output | DATA_W | Read data held for the processor |
| vid_addr | input | ADDR_W | Video fetch address |
| vid_rdata | output | DATA_W | Last fetched video data |
| vid_miss | output | 1 | High during an idle phase-1 slot |
| phi1 | output | 1 | Phase-1 (video) slot indicator |
| phi2 | output | 1 | Phase-2 (processor) slot indicator |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_en | output | 1 | RAM access enable |
| mem_rdata | input | DATA_W | RAM read data for the current address |

## Verification
The assertions assume the RAM is combinational on reads. They also assume `cpu_addr`, `cpu_we`, `cpu_wdata` and `cpu_lock` are steady across the phase-2 slot in which they are used. The bench meets both conditions. Its RAM model reads combinationally and writes only on the edge. It changes every input only just after a falling clock edge, at the start of a processor cycle, and holds it for the whole cycle. Lock is raised only on a read cycle that precedes a write, or on consecutive locked cycles, which are the patterns a read-modify-write would produce.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

    // Slot state. The encoding has no meaning outside the sequencer.
    typedef enum logic [1:0] {
        SLOT_VIDEO = 2'd0,
        SLOT_HOLD  = 2'd1,
        SLOT_CPU   = 2'd2
    } slot_e;

endpackage

// File: rtl/vmx_slot_fsm.sv
module vmx_slot_fsm
    import vmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req,
    output logic phase1,
    output logic phase2,
    output logic slot_idle,
    output logic bus_en
);

    slot_e slot_q;
    slot_e slot_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= SLOT_VIDEO;
        else        slot_q <= slot_d;
    end

    // Transitions
    always_comb begin
        slot_d = slot_q;
        unique case (slot_q)
            SLOT_VIDEO: slot_d = SLOT_CPU;                            // T_VID_DONE
            SLOT_HOLD:  slot_d = SLOT_CPU;                            // T_HOLD_DONE
            SLOT_CPU:   slot_d = lock_req ? SLOT_HOLD : SLOT_VIDEO;   // T_LOCK / T_RELEASE
            default:    slot_d = SLOT_VIDEO;
        endcase
    end

    // Outputs
    always_comb begin
        phase1    = 1'b0;
        phase2    = 1'b0;
        slot_idle = 1'b0;
        bus_en    = 1'b0;
        unique case (slot_q)
            SLOT_VIDEO: begin phase1 = 1'b1; bus_en = 1'b1; end
            SLOT_HOLD:  begin phase1 = 1'b1; slot_idle = 1'b1; end
            SLOT_CPU:   begin phase2 = 1'b1; bus_en = 1'b1; end
            default:    begin phase1 = 1'b1; slot_idle = 1'b1; end
        endcase
    end

endmodule

// File: rtl/vmx_bus_mux.sv
module vmx_bus_mux #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              phase2,
    input  logic              bus_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_en
);

    always_comb begin
        mem_addr  = phase2 ? cpu_addr : vid_addr;
        mem_wdata = cpu_wdata;
        // A write is possible only in the processor slot.
        mem_we    = phase2 & cpu_we;
        mem_en    = bus_en;
    end

endmodule

// File: rtl/vmx_hold_reg.sv
module vmx_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

endmodule

// File: rtl/vmx_arbiter.sv
module vmx_arbiter #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_lock,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [DATA_W-1:0] vid_rdata,
    output logic              vid_miss,
    output logic              phi1,
    output logic              phi2,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_en,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic slot_idle;
    logic bus_en;
    logic vid_load;

    vmx_slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (cpu_lock),
        .phase1   (phi1),
        .phase2   (phi2),
        .slot_idle(slot_idle),
        .bus_en   (bus_en)
    );

    vmx_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .phase2   (phi2),
        .bus_en   (bus_en),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_we   (cpu_we),
        .vid_addr (vid_addr),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_we   (mem_we),
        .mem_en   (mem_en)
    );

    assign vid_miss = slot_idle;
    assign vid_load = phi1 & ~slot_idle;

    // Processor data is captured at the end of phase 2 and held.
    vmx_hold_reg #(.WIDTH(DATA_W)) u_cpu_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (phi2),
        .din  (mem_rdata),
        .dout (cpu_rdata)
    );

    vmx_hold_reg #(.WIDTH(DATA_W)) u_vid_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .load (vid_load),
        .din  (mem_rdata),
        .dout (vid_rdata)
    );

endmodule

// File: rtl/vmx_arbiter_chk.sv
module vmx_arbiter_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic              cpu_lock,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic [ADDR_W-1:0] vid_addr,
    input logic [DATA_W-1:0] vid_rdata,
    input logic              vid_miss,
    input logic              phi1,
    input logic              phi2,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_en,
    input logic [DATA_W-1:0] mem_rdata
);

    assert_swap_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phi1 |=> phi2 && !phi1);
    assert_swap_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |=> phi1 && !phi2);
    assert_no_wr_phase1_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phi1 |-> !mem_we);
    assert_vid_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 && !vid_miss) |-> (mem_addr == vid_addr) && mem_en);
    assert_cpu_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |-> (mem_addr == cpu_addr) && (mem_we == cpu_we) && mem_en);
    assert_cpu_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phi2 |=> cpu_rdata == $past(mem_rdata));
    assert_cpu_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        phi1 |=> $stable(cpu_rdata));
    assert_vid_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 && !vid_miss) |=> vid_rdata == $past(mem_rdata));
    assert_vid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 || vid_miss) |=> $stable(vid_rdata));
    assert_lock_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && cpu_lock) |=> vid_miss && !mem_en && !mem_we);
    assert_unlock_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && !cpu_lock) |=> !vid_miss && mem_en);

endmodule

bind vmx_arbiter vmx_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .cpu_lock (cpu_lock),
    .cpu_rdata(cpu_rdata),
    .vid_addr (vid_addr),
    .vid_rdata(vid_rdata),
    .vid_miss (vid_miss),
    .phi1     (phi1),
    .phi2     (phi2),
    .mem_addr (mem_addr),
    .mem_we   (mem_we),
    .mem_en   (mem_en),
    .mem_rdata(mem_rdata)
);

// File: tb/vmx_arbiter_test.sv
`timescale 1ns/1ps
module vmx_arbiter_test;

    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic          cpu_lock = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic [AW-1:0] vid_addr = '0;
    logic [DW-1:0] vid_rdata;
    logic          vid_miss;
    logic          phi1;
    logic          phi2;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_en;
    logic [DW-1:0] mem_rdata;

    always #10 clk = ~clk;

    vmx_arbiter #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .cpu_lock(cpu_lock), .cpu_rdata(cpu_rdata),
        .vid_addr(vid_addr), .vid_rdata(vid_rdata), .vid_miss(vid_miss),
        .phi1(phi1), .phi2(phi2),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_en(mem_en), .mem_rdata(mem_rdata)
    );

    // RAM model: combinational read, write on the edge.
    logic [DW-1:0] ram [DEPTH];
    always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
    assign mem_rdata = ram[mem_addr];

    logic [DW-1:0] shadow [DEPTH];
    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    bit prev_lock = 0;
    logic [DW-1:0] last_vid = '0;
    logic [DW-1:0] last_cpu = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One processor cycle; entered just after the falling edge in a phase-1 slot.
    task automatic cycle(input logic [AW-1:0] ca, input bit we, input logic [DW-1:0] wd,
                         input bit lk, input logic [AW-1:0] va);
        logic [DW-1:0] exp_vid;
        logic [DW-1:0] exp_cpu;
        bit idle;
        cpu_addr = ca; cpu_we = we; cpu_wdata = wd; cpu_lock = lk; vid_addr = va;
        #2;
        idle = prev_lock;
        chk(phi1 && !phi2, "R2 phase1", {phi1, phi2}, 2'b10);
        chk(!mem_we, "R9 no write in phase1", mem_we, 0);
        if (idle) begin
            chk(vid_miss && !mem_en, "R7 idle slot", {vid_miss, mem_en}, 2'b10);
            exp_vid = last_vid;
        end else begin
            chk(mem_en && !vid_miss && mem_addr == va, "R3 video addr", mem_addr, va);
            exp_vid = shadow[va];
        end
        @(negedge clk); #2;
        chk(phi2 && !phi1, "R8 cpu slot follows", {phi1, phi2}, 2'b01);
        chk(mem_en && mem_addr == ca && mem_we == we, "R4 cpu addr/we", {mem_we, mem_addr}, {we, ca});
        if (we) chk(mem_wdata == wd, "R4 wdata", mem_wdata, wd);
        chk(cpu_rdata == last_cpu, "R5 hold through phase1", cpu_rdata, last_cpu);
        chk(vid_rdata == exp_vid, idle ? "R7 vid kept" : "R6 vid fetch", vid_rdata, exp_vid);
        last_vid = exp_vid;
        exp_cpu = shadow[ca];
        if (we) shadow[ca] = wd;
        @(negedge clk); #2;
        chk(cpu_rdata == exp_cpu, "R5 cpu read", cpu_rdata, exp_cpu);
        last_cpu = exp_cpu;
        prev_lock = lk;
        #0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        #2;
        chk(phi1 && !phi2 && !vid_miss && !mem_we, "R1 reset slot", {phi1, phi2, vid_miss, mem_we}, 4'b1000);
        chk(cpu_rdata == 0 && vid_rdata == 0, "R1 reset data", {cpu_rdata, vid_rdata}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Fill every address while video scans behind.
        for (int a = 0; a < DEPTH; a++)
            cycle(a[AW-1:0], 1'b1, 8'((a * 37 + 5) & 8'hFF), 1'b0, AW'(a + DEPTH - 1));
        // Read back every address, video scanning ahead.
        for (int a = 0; a < DEPTH; a++)
            cycle(a[AW-1:0], 1'b0, 8'h00, 1'b0, AW'(a + 3));
        // Locked read-modify-write sequences.
        for (int a = 0; a < DEPTH; a += 5) begin
            cycle(a[AW-1:0], 1'b0, 8'h00, 1'b1, AW'(a + 1));
            cycle(a[AW-1:0], 1'b1, shadow[a] + 8'd1, 1'b0, AW'(a + 2));
            cycle(a[AW-1:0], 1'b0, 8'h00, 1'b0, a[AW-1:0]);
        end
        // Lock held across several cycles.
        for (int k = 0; k < 4; k++) cycle(AW'(k), 1'b1, 8'(8'hA0 + k), 1'b1, AW'(k + 10));
        cycle(6'd0, 1'b0, 8'h00, 1'b0, 6'd1);
        // Write then immediate read, alternating addresses.
        for (int a = 0; a < 16; a++) begin
            cycle(AW'(a * 3), 1'b1, 8'(a ^ 8'h5A), 1'b0, AW'(a * 3));
            cycle(AW'(a * 3), 1'b0, 8'h00, 1'b0, AW'(a * 3));
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule